// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control engine that sits next to a successive-approximation converter core. It takes register-style controls: enable, a start strobe, continuous mode, a 4-bit sample-window multiplier, an 8-bit interval multiplier and a power-up delay for the converter regulator. From these it drives a sample strobe and a convert strobe to the analog core. The core answers with a done pulse and a 10-bit code. The block captures that code and records completion in a sticky flag. The flag is cleared by a write strobe and is forwarded as an interrupt when the interrupt enable is set.

When enable rises, the block first waits out the regulator delay. Only after that does it accept a start. A start opens a sample window, then a convert phase that lasts until the core reports done. In continuous mode the block launches the next conversion by itself after a timed interval. That interval counts 1.024 ms ticks, which come from a prescaler whose clocks-per-tick count is a parameter. The first conversion still needs an explicit start. Dropping enable aborts any activity at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o, sample_o, convert_o, irq_flag_o and irq_o are 0 and result_o is 0.
- R2: If enable is first sampled high at rising edge e0 with power-up delay D, then a start sampled at edge e0+D is ignored. A start sampled at edge e0+D+1 is accepted. With D = 0, the first edge at which a start is accepted is e0+1.
- R3: An accepted start raises busy_o on the next cycle. busy_o stays 1 through sampling and conversion, and in single mode it returns to 0 in the cycle after the core's done pulse.
- R4: sample_o stays high for exactly M*32 clock cycles for multiplier M in 1..15, and for exactly 1 cycle when M = 0.
- R5: convert_o follows the sample window directly and stays high until conv_done_i is sampled. The code present with that pulse then appears on result_o, and result_o changes at no other time.
- R6: With continuous mode set, the next sample window begins exactly V*TICK_CLKS cycles after the done pulse for an interval multiplier V > 0. For V = 0 it begins in the cycle right after the done pulse. busy_o stays 1 in between.
- R7: Clearing continuous mode during a conversion lets that conversion finish and store its code. No further sample window follows, and busy_o returns to 0.
- R8: A start that arrives while busy does not restart or lengthen the sample window. A start that arrives while enable is low leaves busy_o at 0.
- R9: irq_flag_o is set by every completed conversion and stays set until an irq_clr_i pulse. When a completion and a clear land in the same cycle, the flag ends up set.
- R10: irq_o is 1 exactly when irq_flag_o is 1 and irq_en_i is 1. The flag records completions regardless of irq_en_i.
- R11: Dropping enable forces busy_o, sample_o and convert_o to 0 on the next cycle, whatever phase is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; low aborts and powers down |
| start_wr_i | input | 1 | Start strobe (one write) |
| cont_i | input | 1 | Continuous mode |
| smpl_mult_i | input | 4 | Sample window multiplier (x32 clocks, 0 = 1 clock) |
| ivl_mult_i | input | 8 | Interval multiplier in 1.024 ms ticks |
| pwr_dly_i | input | 8 | Regulator power-up delay in clocks |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_clr_i | input | 1 | Clear strobe for the completion flag |
| conv_done_i | input | 1 | Done pulse from the analog core |
| code_i | input | 10 | Conversion code from the analog core |
| sample_o | output | 1 | Sample strobe to the core |
| convert_o | output | 1 | Convert strobe to the core |
| busy_o | output | 1 | Conversion activity in progress |
| result_o | output | 10 | Last captured code |
| irq_flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Gated interrupt |

## Verification
The assertions assume that the analog core pulses conv_done_i only while convert_o is high. They also assume the control inputs are sampled synchronously, so a value such as the multiplier does not need to hold across a window once that window has been loaded. The bench's core model follows this: it watches convert_o at the falling edge, waits a chosen latency and then raises done for one cycle. All control fields are changed at falling edges, and only between conversions or in the phase under test. The one exception is the start strobe, which is fired on purpose during busy and disabled phases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWRUP,
    ST_READY,
    ST_SAMPLE,
    ST_CONV,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/adc_seq_prescale.sv
// Divides the clock into interval ticks; restarts from zero on clr_i.
module adc_seq_prescale #(
  parameter int TICK_CLKS = 204800
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pcnt_q <= '0;
    end else if (run_i) begin
      pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (pcnt_q == LAST);
endmodule

// File: rtl/adc_seq_timer.sv
// Shared phase countdown: load, step, report zero.
module adc_seq_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int SMPL_W    = 4,
  parameter int SMPL_UNIT = 32,
  parameter int IVL_W     = 8,
  parameter int DLY_W     = 8,
  parameter int TICK_CLKS = 204800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              start_wr_i,
  input  logic              cont_i,
  input  logic [SMPL_W-1:0] smpl_mult_i,
  input  logic [IVL_W-1:0]  ivl_mult_i,
  input  logic [DLY_W-1:0]  pwr_dly_i,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  input  logic              conv_done_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              sample_o,
  output logic              convert_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] result_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  localparam int UNIT_W = $clog2(SMPL_UNIT);
  localparam int SLEN_W = SMPL_W + UNIT_W + 1;
  localparam int TMP_W  = (SLEN_W > IVL_W) ? SLEN_W : IVL_W;
  localparam int TMR_W  = (TMP_W > DLY_W) ? TMP_W : DLY_W;

  seq_state_e        state_q, state_d;
  logic              tmr_load, tmr_zero, tmr_step, tick;
  logic [TMR_W-1:0]  tmr_val, smpl_len;
  logic              complete, pre_clr;
  logic [CODE_W-1:0] result_q;
  logic              flag_q;

  assign smpl_len = (smpl_mult_i == '0) ? TMR_W'(1)
                                        : TMR_W'(smpl_mult_i) * TMR_W'(SMPL_UNIT);
  assign complete = (state_q == ST_CONV) && conv_done_i && en_i;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_OFF: begin
        if (pwr_dly_i == '0) begin
          state_d = ST_READY;
        end else begin
          state_d  = ST_PWRUP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(pwr_dly_i) - 1'b1;
        end
      end
      ST_PWRUP: if (tmr_zero) state_d = ST_READY;
      ST_READY: begin
        if (start_wr_i) begin
          state_d  = ST_SAMPLE;
          tmr_load = 1'b1;
          tmr_val  = smpl_len - 1'b1;
        end
      end
      ST_SAMPLE: if (tmr_zero) state_d = ST_CONV;
      ST_CONV: begin
        if (conv_done_i) begin
          if (!cont_i) begin
            state_d = ST_READY;
          end else if (ivl_mult_i == '0) begin
            state_d  = ST_SAMPLE;
            tmr_load = 1'b1;
            tmr_val  = smpl_len - 1'b1;
          end else begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(ivl_mult_i) - 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!cont_i) begin
          state_d = ST_READY;
        end else if (tmr_zero && tick) begin
          state_d  = ST_SAMPLE;
          tmr_load = 1'b1;
          tmr_val  = smpl_len - 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
    if (!en_i) begin
      state_d  = ST_OFF;
      tmr_load = 1'b0;
    end
  end

  assign tmr_step = (state_q == ST_WAIT) ? tick : 1'b1;
  assign pre_clr  = (state_d == ST_WAIT) && (state_q != ST_WAIT);

  adc_seq_timer #(.W(TMR_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .step_i    (tmr_step),
    .zero_o    (tmr_zero)
  );

  adc_seq_prescale #(.TICK_CLKS(TICK_CLKS)) u_prescale (
    .clk   (clk),
    .rst   (rst),
    .run_i (state_q == ST_WAIT),
    .clr_i (pre_clr),
    .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      result_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (complete) result_q <= code_i;
      if (complete)       flag_q <= 1'b1;
      else if (irq_clr_i) flag_q <= 1'b0;
    end
  end

  assign sample_o   = (state_q == ST_SAMPLE);
  assign convert_o  = (state_q == ST_CONV);
  assign busy_o     = (state_q == ST_SAMPLE) || (state_q == ST_CONV) || (state_q == ST_WAIT);
  assign result_o   = result_q;
  assign irq_flag_o = flag_q;
  assign irq_o      = flag_q && irq_en_i;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              start_wr_i,
  input logic              irq_clr_i,
  input logic              conv_done_i,
  input logic              sample_o,
  input logic              convert_o,
  input logic              busy_o,
  input logic [CODE_W-1:0] result_o,
  input logic              irq_flag_o
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_o, convert_o}));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_wr_i && en_i));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!busy_o && !sample_o && !convert_o));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(convert_o && conv_done_i && en_i) |=> $stable(result_o));

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag_o) |-> $past(convert_o && conv_done_i && en_i));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i && !(convert_o && conv_done_i && en_i)) |=> !irq_flag_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .start_wr_i (start_wr_i),
  .irq_clr_i  (irq_clr_i),
  .conv_done_i(conv_done_i),
  .sample_o   (sample_o),
  .convert_o  (convert_o),
  .busy_o     (busy_o),
  .result_o   (result_o),
  .irq_flag_o (irq_flag_o)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int TICK = 4;
  localparam int DLY  = 3;
  localparam int NV   = 5;
  // {extra start during window, multiplier, done latency, code}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 4'd0,  4'd0, 10'h3FF},
    {1'b1, 4'd1,  4'd2, 10'h000},
    {1'b0, 4'd2,  4'd5, 10'h155},
    {1'b1, 4'd15, 4'd1, 10'h2AA},
    {1'b0, 4'd3,  4'd3, 10'h001}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, start = 0, cont = 0, irq_en = 0, clr = 0, done = 0;
  logic [3:0] mult = 0;
  logic [7:0] ivl = 0, dly = DLY;
  logic [9:0] code = 0;
  logic sample_o, convert_o, busy_o, irq_flag_o, irq_o;
  logic [9:0] result_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.TICK_CLKS(TICK)) dut (
    .clk(clk), .rst(rst), .en_i(en), .start_wr_i(start), .cont_i(cont),
    .smpl_mult_i(mult), .ivl_mult_i(ivl), .pwr_dly_i(dly), .irq_en_i(irq_en),
    .irq_clr_i(clr), .conv_done_i(done), .code_i(code), .sample_o(sample_o),
    .convert_o(convert_o), .busy_o(busy_o), .result_o(result_o),
    .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_conv(input logic [9:0] c, input logic with_clr);
    int g = 0;
    while (!convert_o && g < 2000) begin g++; @(negedge clk); end
    done = 1; code = c; clr = with_clr;
    @(negedge clk);
    done = 0; clr = 0;
  endtask

  task automatic clear_flag();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic run_vec(input logic [18:0] v);
    int w = 0;
    int lat = int'(v[13:10]);
    int exp_w = (v[17:14] == 0) ? 1 : int'(v[17:14]) * 32;
    mult = v[17:14];
    start = 1; @(negedge clk); start = 0;
    chk("R3 busy after start", busy_o, 1);
    while (sample_o && w < 1000) begin
      w++;
      start = v[18] && (w == 5);
      @(negedge clk);
    end
    start = 0;
    chk(v[18] ? "R8 window with busy start" : "R4 window", w, exp_w);
    chk("R5 convert follows window", convert_o, 1);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R5 convert held", convert_o, 1);
    end
    done = 1; code = v[9:0];
    @(negedge clk);
    done = 0;
    chk("R3 busy drops", busy_o, 0);
    chk("R5 result", result_o, int'(v[9:0]));
    chk("R9 flag set", irq_flag_o, 1);
    clear_flag();
    chk("R9 flag cleared", irq_flag_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 flag in reset", irq_flag_o, 0);
    chk("R1 irq in reset", irq_o, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 sample after reset", sample_o, 0);
    chk("R1 result after reset", result_o, 0);

    // R8: start while disabled
    start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk("R8 start while disabled", busy_o, 0);

    // R2: power-up delay, start held over two edges
    en = 1;
    repeat (DLY) @(negedge clk);
    start = 1; @(negedge clk);
    chk("R2 start at e0+D ignored", busy_o, 0);
    @(negedge clk); start = 0;
    chk("R2 start at e0+D+1 accepted", busy_o, 1);
    finish_conv(10'h0AA, 1'b0);
    clear_flag();

    // table walk: R3 R4 R5 R8 R9
    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R6: continuous with interval
    mult = 0; cont = 1; ivl = 2;
    start = 1; @(negedge clk); start = 0;
    finish_conv(10'h011, 1'b0);
    chk("R6 busy in interval", busy_o, 1);
    g = 0;
    while (!sample_o && g < 1000) begin g++; @(negedge clk); end
    chk("R6 interval length", g, 2 * TICK);
    ivl = 0;
    finish_conv(10'h022, 1'b0);
    chk("R6 zero interval restart", sample_o, 1);
    // R7: drop continuous during conversion
    while (!convert_o) @(negedge clk);
    cont = 0;
    finish_conv(10'h033, 1'b0);
    chk("R7 result of last", result_o, 'h033);
    g = 0;
    for (int i = 0; i < 40; i++) begin
      if (sample_o || busy_o) g++;
      @(negedge clk);
    end
    chk("R7 no further conversion", g, 0);
    clear_flag();

    // R9 set wins over clear; R10 gating
    start = 1; @(negedge clk); start = 0;
    finish_conv(10'h044, 1'b1);
    chk("R9 set wins over clear", irq_flag_o, 1);
    chk("R10 irq gated off", irq_o, 0);
    irq_en = 1; #1;
    chk("R10 irq enabled", irq_o, 1);
    clear_flag();
    chk("R10 irq after clear", irq_o, 0);

    // R11: abort mid-sample
    mult = 2;
    start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    en = 0; @(negedge clk);
    chk("R11 busy after disable", busy_o, 0);
    chk("R11 sample after disable", sample_o, 0);
    chk("R11 convert after disable", convert_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule